// File: doc/BRIEF.md
# Banked Interrupt Status Aggregator

This block gathers up to 160 interrupt request inputs into five 32-bit banks and turns them into two interrupt lines, one for functional events and one for error events. The banks hold 32, 32, 24, 32 and 17 live sources, which makes 137 sources in all. Each bank has two registers. The enable register holds one mask bit per source. The pending register latches every rising edge of a source. Software clears a pending bit by writing a 1 to it.

Every source is identified by its bit position. Its number is the bank index times 32, plus the bit within the bank. The unused top bits of a bank therefore leave holes in the numbering. Banks 0 to 2 make up the functional group and banks 3 and 4 make up the error group. Each group owns one registered output line. Each group also has a read-only register that reports its lowest pending and enabled source number, so a handler can service sources in ascending order without scanning the banks itself.

Software accesses the block over a single-cycle register port. A write completes on the clock edge where the write strobe is sampled. A read returns data combinationally from the address.

Top module: `irq_bank_aggr`

## Requirements
- R1: After reset, every enable and pending register reads 0, both output lines are low, and both lowest-source registers read 0x100.
- R2: An enable register stores the written value and reads it back. Bit positions at or above the bank's live source count (32, 32, 24, 32, 17) read 0 whatever is written.
- R3: A 0-to-1 transition on a live source sets its pending bit on the next clock edge, whatever its enable bit. Holding the source high does not set the bit again after it is cleared.
- R4: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R5: When a rising edge and a write-1 clear reach the same pending bit in the same cycle, the bit ends up set.
- R6: Edges on source positions that are not live never set a pending bit, and those positions read 0.
- R7: The functional line goes high one clock after any bit in banks 0 to 2 is both pending and enabled. It goes low one clock after no such bit remains.
- R8: The error line follows the same rule for banks 3 and 4. It is independent of the functional banks.
- R9: A lowest-source register reads 32*bank + bit for the lowest-numbered pending and enabled source of its group. It reads 0x100 (bit 8 set) when the group has none.
- R10: The register map is as follows. Bank b has its enable register at address 2b and its pending register at address 2b+1. The functional lowest-source register is at address 10 and the error one is at address 11. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 160 | Interrupt sources; bit n is source n |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_fn_o | output | 1 | Functional group interrupt line, active high |
| irq_err_o | output | 1 | Error group interrupt line, active high |

## Verification
The bench instantiates the block with its default parameters: five banks, three of them functional, 32-bit banks and live widths 32/32/24/32/17. This configuration exercises the uneven layout. It covers the partial bank 2 and the 17-bit bank 4 with their masked upper bits, bits 31 at the boundaries of banks 0 and 3, and a lowest-source search that crosses from bank 3 into bank 4. Running the default configuration also makes the same-cycle set-and-clear race, a held source that must not set its bit again, and a reset applied mid-run observable at the ports.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

  // Register slots per bank: enable first, pending second.
  localparam int unsigned REGS_PER_BANK = 2;
  localparam int unsigned SLOT_ENABLE   = 0;
  localparam int unsigned SLOT_PENDING  = 1;

  // Address of the enable or pending register of a bank.
  function automatic int unsigned bank_reg_addr(int unsigned bank, int unsigned slot);
    return bank * REGS_PER_BANK + slot;
  endfunction

  // Lowest-source registers sit just past the bank registers.
  function automatic int unsigned low_reg_addr(int unsigned num_banks, int unsigned grp);
    return num_banks * REGS_PER_BANK + grp;
  endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned LIVE  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src_i,
  input  logic             wr_en_i,
  input  logic             wr_pend_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] en_o,
  output logic [WIDTH-1:0] pend_o
);

  localparam int unsigned     DEAD = (LIVE >= WIDTH) ? 0 : WIDTH - LIVE;
  localparam logic [WIDTH-1:0] LIVE_MASK = {WIDTH{1'b1}} >> DEAD;

  logic [WIDTH-1:0] src_q, src_d;
  logic [WIDTH-1:0] en_q, en_d;
  logic [WIDTH-1:0] pend_q, pend_d;
  logic [WIDTH-1:0] rise;
  logic [WIDTH-1:0] clr;

  always_comb begin
    src_d  = src_i & LIVE_MASK;
    rise   = src_d & ~src_q;
    clr    = wr_pend_i ? (wdata_i & LIVE_MASK) : '0;
    // A new edge takes precedence over a clear in the same cycle.
    pend_d = (pend_q & ~clr) | rise;
    en_d   = wdata_i & LIVE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en_i) begin
      en_q <= en_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/irq_lowest_find.sv
module irq_lowest_find #(
  parameter int unsigned GRP_W = 96,
  parameter int unsigned BASE  = 0,
  parameter int unsigned NUM_W = 8
) (
  input  logic [GRP_W-1:0] pe_i,
  output logic [NUM_W:0]   low_o
);

  // Walk downward so the lowest set bit is the last one written.
  always_comb begin
    low_o = {1'b1, {NUM_W{1'b0}}};
    for (int i = GRP_W - 1; i >= 0; i--) begin
      if (pe_i[i]) begin
        low_o = {1'b0, NUM_W'(BASE + i)};
      end
    end
  end

endmodule

// File: rtl/irq_bank_aggr.sv
module irq_bank_aggr
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned FN_BANKS  = 3,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned BANK_LIVE [NUM_BANKS] = '{32, 32, 24, 32, 17},
  localparam int unsigned SRC_W    = NUM_BANKS * BANK_W,
  localparam int unsigned ADDR_W   = $clog2(NUM_BANKS * REGS_PER_BANK + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  output logic              irq_fn_o,
  output logic              irq_err_o
);

  localparam int unsigned ERR_BANKS = NUM_BANKS - FN_BANKS;
  localparam int unsigned FN_W      = FN_BANKS * BANK_W;
  localparam int unsigned ERR_W     = ERR_BANKS * BANK_W;
  localparam int unsigned NUM_W     = $clog2(SRC_W);
  localparam int unsigned LOW_FN_A  = low_reg_addr(NUM_BANKS, 0);
  localparam int unsigned LOW_ERR_A = low_reg_addr(NUM_BANKS, 1);

  function automatic logic [SRC_W-1:0] build_live_mask();
    logic [SRC_W-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int i = 0; i < BANK_W; i++) begin
        if (i < BANK_LIVE[b]) m[b*BANK_W+i] = 1'b1;
      end
    end
    return m;
  endfunction

  localparam logic [SRC_W-1:0] LIVE_MASK = build_live_mask();

  logic [SRC_W-1:0] en_all;
  logic [SRC_W-1:0] pend_all;
  logic [SRC_W-1:0] pe_all;
  logic [NUM_W:0]   low_fn;
  logic [NUM_W:0]   low_err;
  logic             fn_d, fn_q;
  logic             err_d, err_q;
  logic [BANK_W-1:0] rdata_d;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_en, wr_pend;
    assign wr_en   = bus_we && (bus_addr == ADDR_W'(bank_reg_addr(b, SLOT_ENABLE)));
    assign wr_pend = bus_we && (bus_addr == ADDR_W'(bank_reg_addr(b, SLOT_PENDING)));

    irq_src_bank #(
      .WIDTH (BANK_W),
      .LIVE  (BANK_LIVE[b])
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i[b*BANK_W +: BANK_W]),
      .wr_en_i   (wr_en),
      .wr_pend_i (wr_pend),
      .wdata_i   (bus_wdata),
      .en_o      (en_all[b*BANK_W +: BANK_W]),
      .pend_o    (pend_all[b*BANK_W +: BANK_W])
    );
  end

  assign pe_all = en_all & pend_all;

  irq_lowest_find #(
    .GRP_W (FN_W),
    .BASE  (0),
    .NUM_W (NUM_W)
  ) u_low_fn (
    .pe_i  (pe_all[FN_W-1:0]),
    .low_o (low_fn)
  );

  irq_lowest_find #(
    .GRP_W (ERR_W),
    .BASE  (FN_W),
    .NUM_W (NUM_W)
  ) u_low_err (
    .pe_i  (pe_all[SRC_W-1:FN_W]),
    .low_o (low_err)
  );

  // Output line next-state and registers.
  always_comb begin
    fn_d  = |pe_all[FN_W-1:0];
    err_d = |pe_all[SRC_W-1:FN_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      fn_q  <= fn_d;
      err_q <= err_d;
    end
  end

  assign irq_fn_o  = fn_q;
  assign irq_err_o = err_q;

  // Read decode.
  always_comb begin
    rdata_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == ADDR_W'(bank_reg_addr(b, SLOT_ENABLE)))
        rdata_d = en_all[b*BANK_W +: BANK_W];
      if (bus_addr == ADDR_W'(bank_reg_addr(b, SLOT_PENDING)))
        rdata_d = pend_all[b*BANK_W +: BANK_W];
    end
    if (bus_addr == ADDR_W'(LOW_FN_A))  rdata_d = BANK_W'(low_fn);
    if (bus_addr == ADDR_W'(LOW_ERR_A)) rdata_d = BANK_W'(low_err);
  end

  assign bus_rdata = rdata_d;

endmodule

// File: rtl/irq_bank_aggr_chk.sv
module irq_bank_aggr_chk #(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned FN_BANKS  = 3,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned NUM_W     = 8,
  parameter logic [NUM_BANKS*BANK_W-1:0] LIVE_MASK = '1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_BANKS*BANK_W-1:0] src_i,
  input logic                        bus_we,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [BANK_W-1:0]           bus_wdata,
  input logic [NUM_BANKS*BANK_W-1:0] en_all,
  input logic [NUM_BANKS*BANK_W-1:0] pend_all,
  input logic [NUM_W:0]              low_fn,
  input logic [NUM_W:0]              low_err,
  input logic                        irq_fn_o,
  input logic                        irq_err_o
);

  localparam int unsigned SRC_W = NUM_BANKS * BANK_W;
  localparam int unsigned FN_W  = FN_BANKS * BANK_W;

  logic [SRC_W-1:0] seen_q;
  logic [SRC_W-1:0] rise_v;
  logic [SRC_W-1:0] clr_v;
  logic             fn_any, err_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= src_i & LIVE_MASK;
  end

  always_comb begin
    rise_v = src_i & ~seen_q & LIVE_MASK;
    clr_v  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_we && bus_addr == ADDR_W'(2*b+1)) clr_v[b*BANK_W +: BANK_W] = bus_wdata;
    end
    fn_any  = |(en_all[FN_W-1:0] & pend_all[FN_W-1:0]);
    err_any = |(en_all[SRC_W-1:FN_W] & pend_all[SRC_W-1:FN_W]);
  end

  AST_PEND_DEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all & ~LIVE_MASK) == '0); // R6
  AST_EN_DEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all & ~LIVE_MASK) == '0); // R2
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise_v) & ~pend_all) == '0)); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_v & ~rise_v) & pend_all) == '0)); // R4
  AST_FN_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fn_any |=> irq_fn_o); // R7
  AST_FN_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !fn_any |=> !irq_fn_o); // R7
  AST_ERR_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |=> irq_err_o); // R8
  AST_ERR_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !err_any |=> !irq_err_o); // R8
  AST_LOW_FN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    low_fn[NUM_W] == !fn_any); // R9
  AST_LOW_ERR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    low_err[NUM_W] == !err_any); // R9

endmodule

bind irq_bank_aggr irq_bank_aggr_chk #(
  .NUM_BANKS (NUM_BANKS),
  .FN_BANKS  (FN_BANKS),
  .BANK_W    (BANK_W),
  .ADDR_W    (ADDR_W),
  .NUM_W     (NUM_W),
  .LIVE_MASK (LIVE_MASK)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_i     (src_i),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .en_all    (en_all),
  .pend_all  (pend_all),
  .low_fn    (low_fn),
  .low_err   (low_err),
  .irq_fn_o  (irq_fn_o),
  .irq_err_o (irq_err_o)
);

// File: tb/irq_bank_aggr_tb_top.sv
module irq_bank_aggr_tb_top;

  localparam int SRC_W = 160;

  // Step kinds.
  localparam logic [2:0] OP_IDLE  = 3'd0;
  localparam logic [2:0] OP_WR    = 3'd1;
  localparam logic [2:0] OP_RD    = 3'd2;
  localparam logic [2:0] OP_SRCHI = 3'd3;
  localparam logic [2:0] OP_SRCLO = 3'd4;
  localparam logic [2:0] OP_LINES = 3'd5;
  localparam logic [2:0] OP_WRSRC = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 59;
  localparam step_t STEPS [NSTEP] = '{
    '{OP_RD,    4'd0,  32'h0,        32'h0,        4'd1},  // R1 enable bank0
    '{OP_RD,    4'd10, 32'h0,        32'h100,      4'd1},  // R1 fn lowest none
    '{OP_RD,    4'd11, 32'h0,        32'h100,      4'd1},  // R1 err lowest none
    '{OP_LINES, 4'd0,  32'h0,        32'h0,        4'd1},  // R1 lines low
    '{OP_SRCHI, 4'd0,  32'd5,        32'h0,        4'd3},
    '{OP_IDLE,  4'd0,  32'h0,        32'h0,        4'd0},
    '{OP_RD,    4'd1,  32'h0,        32'h20,       4'd3},  // R3 set while masked
    '{OP_LINES, 4'd0,  32'h0,        32'h0,        4'd7},  // R7 masked keeps low
    '{OP_RD,    4'd10, 32'h0,        32'h100,      4'd9},  // R9 masked not reported
    '{OP_WR,    4'd0,  32'hFFFFFFFF, 32'h0,        4'd2},
    '{OP_IDLE,  4'd0,  32'h0,        32'h0,        4'd0},
    '{OP_LINES, 4'd0,  32'h0,        32'h1,        4'd7},  // R7 fn high
    '{OP_RD,    4'd0,  32'h0,        32'hFFFFFFFF, 4'd2},  // R2 readback
    '{OP_RD,    4'd10, 32'h0,        32'd5,        4'd9},  // R9
    '{OP_SRCHI, 4'd0,  32'd3,        32'h0,        4'd3},
    '{OP_IDLE,  4'd0,  32'h0,        32'h0,        4'd0},
    '{OP_RD,    4'd10, 32'h0,        32'd3,        4'd9},  // R9 lowest of 3,5
    '{OP_WR,    4'd1,  32'h8,        32'h0,        4'd4},
    '{OP_RD,    4'd10, 32'h0,        32'd5,        4'd4},  // R4 bit 3 cleared
    '{OP_RD,    4'd1,  32'h0,        32'h20,       4'd4},  // R4 / R3 held src no reset
    '{OP_WR,    4'd1,  32'h0,        32'h0,        4'd4},
    '{OP_RD,    4'd1,  32'h0,        32'h20,       4'd4},  // R4 write 0 no effect
    '{OP_WR,    4'd4,  32'hFFFFFFFF, 32'h0,        4'd2},
    '{OP_RD,    4'd4,  32'h0,        32'h00FFFFFF, 4'd2},  // R2 bank2 24 live
    '{OP_SRCHI, 4'd0,  32'd90,       32'h0,        4'd6},
    '{OP_IDLE,  4'd0,  32'h0,        32'h0,        4'd0},
    '{OP_RD,    4'd5,  32'h0,        32'h0,        4'd6},  // R6 dead source
    '{OP_SRCHI, 4'd0,  32'd70,       32'h0,        4'd3},
    '{OP_IDLE,  4'd0,  32'h0,        32'h0,        4'd0},
    '{OP_RD,    4'd5,  32'h0,        32'h40,       4'd3},  // R3 bank2 bit6
    '{OP_RD,    4'd10, 32'h0,        32'd5,        4'd9},  // R9 across banks
    '{OP_WR,    4'd8,  32'hFFFFFFFF, 32'h0,        4'd2},
    '{OP_RD,    4'd8,  32'h0,        32'h0001FFFF, 4'd2},  // R2 bank4 17 live
    '{OP_LINES, 4'd0,  32'h0,        32'h1,        4'd8},  // R8 err still low
    '{OP_SRCHI, 4'd0,  32'd144,      32'h0,        4'd8},
    '{OP_IDLE,  4'd0,  32'h0,        32'h0,        4'd0},
    '{OP_LINES, 4'd0,  32'h0,        32'h3,        4'd8},  // R8 err high
    '{OP_RD,    4'd11, 32'h0,        32'd144,      4'd9},  // R9 bank4 bit16
    '{OP_WR,    4'd6,  32'h1,        32'h0,        4'd2},
    '{OP_SRCHI, 4'd0,  32'd96,       32'h0,        4'd3},
    '{OP_IDLE,  4'd0,  32'h0,        32'h0,        4'd0},
    '{OP_RD,    4'd11, 32'h0,        32'd96,       4'd9},  // R9 96 below 144
    '{OP_RD,    4'd7,  32'h0,        32'h1,        4'd10}, // R10 pending bank3 address
    '{OP_RD,    4'd12, 32'h0,        32'h0,        4'd10}, // R10 unused address
    '{OP_WR,    4'd7,  32'h1,        32'h0,        4'd4},
    '{OP_WR,    4'd9,  32'h00010000, 32'h0,        4'd4},
    '{OP_IDLE,  4'd0,  32'h0,        32'h0,        4'd0},
    '{OP_LINES, 4'd0,  32'h0,        32'h1,        4'd8},  // R8 err falls alone
    '{OP_RD,    4'd11, 32'h0,        32'h100,      4'd9},  // R9 none
    '{OP_SRCLO, 4'd0,  32'd5,        32'h0,        4'd0},
    '{OP_WR,    4'd1,  32'h20,       32'h0,        4'd4},
    '{OP_RD,    4'd1,  32'h0,        32'h0,        4'd4},  // R4 cleared
    '{OP_WRSRC, 4'd1,  32'h20,       32'd5,        4'd5},
    '{OP_RD,    4'd1,  32'h0,        32'h20,       4'd5},  // R5 set wins
    '{OP_WR,    4'd0,  32'h0,        32'h0,        4'd7},
    '{OP_WR,    4'd4,  32'h0,        32'h0,        4'd7},
    '{OP_IDLE,  4'd0,  32'h0,        32'h0,        4'd0},
    '{OP_LINES, 4'd0,  32'h0,        32'h0,        4'd7},  // R7 masked drops line
    '{OP_RD,    4'd1,  32'h0,        32'h20,       4'd3}   // R3 pending kept while masked
  };

  logic             clk;
  logic             rst_n;
  logic [SRC_W-1:0] src_i;
  logic             bus_we;
  logic [3:0]       bus_addr;
  logic [31:0]      bus_wdata;
  logic [31:0]      bus_rdata;
  logic             irq_fn_o;
  logic             irq_err_o;

  int checks;
  int failures;

  irq_bank_aggr dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_fn_o  (irq_fn_o),
    .irq_err_o (irq_err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd_check(input int req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, "register read", bus_rdata, exp);
  endtask

  task automatic do_step(input step_t s);
    @(negedge clk);
    bus_we = 1'b0;
    case (s.op)
      OP_WR: begin
        bus_we = 1'b1; bus_addr = s.addr; bus_wdata = s.data;
      end
      OP_RD: rd_check(int'(s.req), s.addr, s.exp);
      OP_SRCHI: src_i[s.data[7:0]] = 1'b1;
      OP_SRCLO: src_i[s.data[7:0]] = 1'b0;
      OP_LINES: check(int'(s.req), "lines {err,fn}", {30'd0, irq_err_o, irq_fn_o}, s.exp);
      OP_WRSRC: begin
        bus_we = 1'b1; bus_addr = s.addr; bus_wdata = s.data;
        src_i[s.exp[7:0]] = 1'b1;
      end
      default: ;
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; src_i = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NSTEP; k++) do_step(STEPS[k]);

    // Reset in mid-run: clear everything, lines drop at once (R1).
    @(negedge clk);
    bus_we = 1'b0;
    src_i  = '0;
    rst_n  = 1'b0;
    #1;
    check(1, "fn line in reset", {31'd0, irq_fn_o}, 32'h0);
    check(1, "err line in reset", {31'd0, irq_err_o}, 32'h0);
    rd_check(1, 4'd4, 32'h0);
    rd_check(1, 4'd5, 32'h0);
    rd_check(1, 4'd10, 32'h100);
    @(negedge clk);
    rst_n = 1'b1;

    // Boundary: bank0 bit31 is source 31, bank3 bit31 is source 127 (R9).
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h80000000;
    @(negedge clk);
    bus_addr = 4'd6; bus_wdata = 32'h80000000;
    @(negedge clk);
    bus_we = 1'b0;
    src_i[31]  = 1'b1;
    src_i[127] = 1'b1;
    @(negedge clk);
    rd_check(9, 4'd10, 32'd31);
    rd_check(9, 4'd11, 32'd127);
    @(negedge clk);
    check(7, "fn line after bit31", {31'd0, irq_fn_o}, 32'h1);
    check(8, "err line after bit127", {31'd0, irq_err_o}, 32'h1);
    // Single-cycle pulse on dead position of bank4 bit 31 (source 159) (R6).
    src_i[159] = 1'b1;
    @(negedge clk);
    src_i[159] = 1'b0;
    @(negedge clk);
    rd_check(6, 4'd9, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule